// File: doc/BRIEF.md
# Four-Channel PWM Generator with Staged Updates

This block produces four independent left-aligned pulse-width modulated outputs, each set up through a small memory-mapped register bus with a write strobe, a read strobe and a one-cycle read latency. Software starts channels by writing ones into a set register, stops them by writing ones into a clear register, and can read back which channels are running from a status word.

Each channel owns a mode word, a duty value, a period value and a staging register. The mode word holds a power-of-two clock prescaler, an output inversion bit and a bit that says whether a staged value goes to duty or to period. While a channel is stopped, duty and period are written directly. While it runs, the direct writes are dropped and new values go through the staging register. A staged value waits and is copied into its target only when the channel counter wraps, so a running waveform never sees a cut-short or stretched period.

Top module: `pwm_bank`

## Requirements
- R1: After reset every channel is stopped, every output is low, and the status word, every mode word, every duty value and every period value read as zero.
- R2: A write to offset 0x04 starts each channel n whose bit n of the write data is 1 and leaves the others unchanged; the status word at offset 0x0C reports running channels in bits [3:0], one bit per channel, and is otherwise zero.
- R3: A write to offset 0x08 stops each channel n whose bit n is 1 and leaves the others unchanged; a stopped channel drives its idle level, which equals its inversion bit, and its counter restarts from zero when it is started again.
- R4: Channel n's registers sit at 0x200 + n*0x20: mode at +0x00, duty at +0x04, period at +0x08, staging at +0x10. Read data appears on the cycle after the read strobe. Duty and period keep the low 16 bits of the written word and read back with bits [31:16] zero.
- R5: On each prescaled tick a running channel's counter steps from 0 up to period-1 and then wraps to 0; with inversion off the output is high while the counter is below duty, so over period*2^prescale consecutive clock cycles the output is high for duty*2^prescale cycles.
- R6: Mode bits [3:0] hold the prescale value; the counter advances once every 2^prescale clock cycles (legal values 0 to 10, larger values behave as 10).
- R7: Mode bit 9 inverts the output: with it set the output is low while the counter is below duty and high otherwise, and the idle level is high.
- R8: A duty value greater than or equal to a nonzero period keeps a running output at its active level; a period of 0 keeps the output at its idle level.
- R9: Writes to duty or period are accepted while the channel is stopped and have no effect while it runs.
- R10: A write to the staging register is held pending; mode bit 10 at write time selects the target (0 = duty, 1 = period); the pending value replaces the target at the next counter wrap of a running channel and is not visible in the target before then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| pwm_out | output | 4 | One waveform per channel, bit n is channel n |

## Verification
The hardest case to reach is a staging write that lands in the middle of a running period, where the new value must stay invisible until the wrap. The bench watches a channel's output for a rising edge, which marks the cycle right after a wrap, writes the staging register at once, reads the target back to see the old value, then reads it again after more than one full period to see the new one. Waveform checks count active cycles over a whole number of periods so the result does not depend on where in the period counting starts.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    // Bus word and global register offsets
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned OFS_ENA  = 32'h004;
    localparam int unsigned OFS_DIS  = 32'h008;
    localparam int unsigned OFS_STAT = 32'h00C;

    // Per-channel bank placement
    localparam int unsigned BANK_BASE = 32'h200;
    localparam int unsigned BANK_LG2  = 5;

    // Register offsets inside one channel bank
    localparam logic [BANK_LG2-1:0] CR_MODE = 5'h00;
    localparam logic [BANK_LG2-1:0] CR_DUTY = 5'h04;
    localparam logic [BANK_LG2-1:0] CR_PER  = 5'h08;
    localparam logic [BANK_LG2-1:0] CR_UPD  = 5'h10;

    // Mode word field positions
    localparam int unsigned PRES_W  = 4;
    localparam int unsigned POL_BIT = 9;
    localparam int unsigned TGT_BIT = 10;

    typedef enum logic {
        UPD_DUTY = 1'b0,
        UPD_PER  = 1'b1
    } upd_tgt_e;

    typedef struct packed {
        logic [PRES_W-1:0] pres;
        logic              pol;
        upd_tgt_e          tgt;
    } chan_mode_t;

    function automatic chan_mode_t mode_unpack(input logic [WORD_W-1:0] w);
        chan_mode_t m;
        m.pres = w[PRES_W-1:0];
        m.pol  = w[POL_BIT];
        m.tgt  = upd_tgt_e'(w[TGT_BIT]);
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] mode_pack(input chan_mode_t m);
        logic [WORD_W-1:0] w;
        w               = '0;
        w[PRES_W-1:0]   = m.pres;
        w[POL_BIT]      = m.pol;
        w[TGT_BIT]      = m.tgt;
        return w;
    endfunction

endpackage

// File: rtl/pwm_presc.sv
module pwm_presc
    import pwm_bank_pkg::*;
#(
    parameter int unsigned PRES_MAX = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PRES_W-1:0] pres,
    output logic              tick
);

    localparam int unsigned DIV_W = (PRES_MAX > 0) ? PRES_MAX : 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] mask;
    logic [31:0]      eff;

    always_comb begin
        // values above the legal range saturate at the largest divider
        eff = 32'(pres);
        if (eff > PRES_MAX) begin
            eff = PRES_MAX;
        end
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (32'(i) < eff);
        end
        tick  = run && ((div_q & mask) == mask);
        div_d = run ? div_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_bank_pkg::*;
#(
    parameter int unsigned VAL_W    = 16,
    parameter int unsigned PRES_MAX = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_mode,
    input  logic              wr_duty,
    input  logic              wr_per,
    input  logic              wr_upd,
    input  logic [WORD_W-1:0] wdata,
    output chan_mode_t        mode_o,
    output logic [VAL_W-1:0]  duty_o,
    output logic [VAL_W-1:0]  per_o,
    output logic              out_o
);

    typedef struct packed {
        chan_mode_t       mode;
        logic [VAL_W-1:0] duty;
        logic [VAL_W-1:0] per;
        logic [VAL_W-1:0] cnt;
        logic             pend;
        upd_tgt_e         pend_tgt;
        logic [VAL_W-1:0] pend_val;
    } chan_st_t;

    chan_st_t       st_d, st_q;
    logic           tick;
    logic [VAL_W:0] cnt_inc;
    logic           wrap;
    logic           active;
    logic           unused_hi;

    assign unused_hi = ^wdata[WORD_W-1:VAL_W];

    pwm_presc #(
        .PRES_MAX(PRES_MAX)
    ) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .pres (st_q.mode.pres),
        .tick (tick)
    );

    always_comb begin
        st_d    = st_q;
        cnt_inc = (VAL_W+1)'(st_q.cnt) + 1'b1;
        // a zero period wraps on every tick, which keeps the counter at 0
        wrap    = cnt_inc >= (VAL_W+1)'(st_q.per);

        if (wr_mode) begin
            st_d.mode = mode_unpack(wdata);
        end

        if (!run) begin
            st_d.cnt = '0;
            if (wr_duty) begin
                st_d.duty = wdata[VAL_W-1:0];
            end
            if (wr_per) begin
                st_d.per = wdata[VAL_W-1:0];
            end
        end else if (tick) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
            if (wrap && st_q.pend) begin
                st_d.pend = 1'b0;
                if (st_q.pend_tgt == UPD_PER) begin
                    st_d.per = st_q.pend_val;
                end else begin
                    st_d.duty = st_q.pend_val;
                end
            end
        end

        // a staging write at the wrap cycle waits for the next wrap
        if (wr_upd) begin
            st_d.pend     = 1'b1;
            st_d.pend_tgt = st_q.mode.tgt;
            st_d.pend_val = wdata[VAL_W-1:0];
        end

        active = run && (st_q.per != '0) && (st_q.cnt < st_q.duty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign duty_o = st_q.duty;
    assign per_o  = st_q.per;
    assign out_o  = active ^ st_q.mode.pol;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NCH      = 4,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned VAL_W    = 16,
    parameter int unsigned PRES_MAX = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_out
);

    localparam int unsigned SEL_W   = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int unsigned TAG_LSB = BANK_LG2 + SEL_W;
    localparam int unsigned TAG_W   = ADDR_W - TAG_LSB;
    localparam logic [TAG_W-1:0] BANK_TAG = TAG_W'(BANK_BASE >> TAG_LSB);

    typedef struct packed {
        logic [NCH-1:0]    run;
        logic [WORD_W-1:0] rdata;
    } top_st_t;

    top_st_t           st_d, st_q;

    chan_mode_t        chan_mode [NCH];
    logic [VAL_W-1:0]  chan_duty [NCH];
    logic [VAL_W-1:0]  chan_per  [NCH];
    logic [NCH-1:0]    chan_pol;
    logic [NCH-1:0]    chan_run;

    logic              in_bank;
    logic [SEL_W-1:0]  ch_sel;
    logic [BANK_LG2-1:0] creg;
    logic [NCH-1:0]    wr_mode_v, wr_duty_v, wr_per_v, wr_upd_v;
    logic [WORD_W-1:0] rd_word;

    // address decode and per-channel write strobes
    always_comb begin
        in_bank = (bus_addr[ADDR_W-1:TAG_LSB] == BANK_TAG);
        ch_sel  = bus_addr[BANK_LG2 +: SEL_W];
        creg    = bus_addr[BANK_LG2-1:0];
        for (int i = 0; i < NCH; i++) begin
            wr_mode_v[i] = bus_we && in_bank && (ch_sel == SEL_W'(i)) && (creg == CR_MODE);
            wr_duty_v[i] = bus_we && in_bank && (ch_sel == SEL_W'(i)) && (creg == CR_DUTY);
            wr_per_v[i]  = bus_we && in_bank && (ch_sel == SEL_W'(i)) && (creg == CR_PER);
            wr_upd_v[i]  = bus_we && in_bank && (ch_sel == SEL_W'(i)) && (creg == CR_UPD);
        end
    end

    // read multiplexer
    always_comb begin
        rd_word = '0;
        if (bus_addr == ADDR_W'(OFS_STAT)) begin
            rd_word[NCH-1:0] = st_q.run;
        end
        for (int i = 0; i < NCH; i++) begin
            if (in_bank && (ch_sel == SEL_W'(i))) begin
                case (creg)
                    CR_MODE: rd_word = mode_pack(chan_mode[i]);
                    CR_DUTY: rd_word = WORD_W'(chan_duty[i]);
                    CR_PER:  rd_word = WORD_W'(chan_per[i]);
                    default: rd_word = '0;
                endcase
            end
        end
    end

    // next state: run set/clear and registered read data
    always_comb begin
        st_d = st_q;
        if (bus_we && (bus_addr == ADDR_W'(OFS_ENA))) begin
            st_d.run = st_q.run | bus_wdata[NCH-1:0];
        end
        if (bus_we && (bus_addr == ADDR_W'(OFS_DIS))) begin
            st_d.run = st_q.run & ~bus_wdata[NCH-1:0];
        end
        if (bus_re) begin
            st_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chan_run  = st_q.run;
    assign bus_rdata = st_q.rdata;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_chan #(
            .VAL_W   (VAL_W),
            .PRES_MAX(PRES_MAX)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (st_q.run[g]),
            .wr_mode(wr_mode_v[g]),
            .wr_duty(wr_duty_v[g]),
            .wr_per (wr_per_v[g]),
            .wr_upd (wr_upd_v[g]),
            .wdata  (bus_wdata),
            .mode_o (chan_mode[g]),
            .duty_o (chan_duty[g]),
            .per_o  (chan_per[g]),
            .out_o  (pwm_out[g])
        );
        assign chan_pol[g] = chan_mode[g].pol;
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned VAL_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [NCH-1:0]    ena_bits,
    input logic [NCH-1:0]    pwm_out,
    input logic [NCH-1:0]    chan_run,
    input logic [NCH-1:0]    chan_pol,
    input logic [VAL_W-1:0]  chan_duty [NCH],
    input logic [VAL_W-1:0]  chan_per  [NCH]
);

    // R2
    ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_ENA))
        |=> ((chan_run & $past(ena_bits)) == $past(ena_bits)));

    // R3
    dis_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_DIS))
        |=> ((chan_run & $past(ena_bits)) == '0));

    // R2
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(chan_run));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R3
        idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_run[i] |-> (pwm_out[i] == chan_pol[i]));

        // R8
        zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_per[i] == '0) |-> (pwm_out[i] == chan_pol[i]));

        // R8
        full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_run[i] && chan_per[i] != '0 && chan_duty[i] >= chan_per[i])
            |-> (pwm_out[i] != chan_pol[i]));

        // R10
        frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!chan_run[i] && !bus_we)
            |=> ($stable(chan_duty[i]) && $stable(chan_per[i])));
    end

endmodule

bind pwm_bank pwm_bank_chk #(
    .NCH   (NCH),
    .ADDR_W(ADDR_W),
    .VAL_W (VAL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .ena_bits (bus_wdata[NCH-1:0]),
    .pwm_out  (pwm_out),
    .chan_run (chan_run),
    .chan_pol (chan_pol),
    .chan_duty(chan_duty),
    .chan_per (chan_per)
);

// File: tb/pwm_bank_tb_top.sv
`timescale 1ns/1ps
module pwm_bank_tb_top;

    logic        clk;
    logic        rst_n;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic        bus_re;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        re_s = 1'b0;

    pwm_bank dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .bus_re   (bus_re),
        .bus_rdata(bus_rdata),
        .pwm_out  (pwm_out)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per completed read
    always @(posedge clk) re_s <= bus_re;
    always @(negedge clk) begin
        if (re_s) begin
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    function automatic logic [11:0] ch_addr(input int ch, input int ofs);
        return 12'(32'h200 + ch * 32'h20 + ofs);
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        bus_re   = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_re   = 1'b0;
    endtask

    task automatic count_high(input int ch, input int ncyc, output int hi);
        hi = 0;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
        end
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        @(negedge clk);
        prev = pwm_out[ch];
        forever begin
            @(negedge clk);
            if (!prev && pwm_out[ch]) break;
            prev = pwm_out[ch];
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int hi;
        rst_n     = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        check("R1 outputs after reset", 32'(pwm_out), 32'h0);
        rd(12'h00C, 32'h0, "R1 status after reset");
        rd(ch_addr(0, 0), 32'h0, "R1 mode after reset");
        rd(ch_addr(0, 4), 32'h0, "R1 duty after reset");
        rd(ch_addr(3, 8), 32'h0, "R1 period after reset");

        // R4 R9 direct writes while stopped, upper bits dropped
        wr(ch_addr(0, 4), 32'hFFFF_0003);
        wr(ch_addr(0, 8), 32'h0000_000A);
        rd(ch_addr(0, 4), 32'h3, "R4 R9 duty readback low 16 bits");
        rd(ch_addr(0, 8), 32'hA, "R9 period accepted while stopped");

        // R2 start channel 0
        wr(12'h004, 32'h1);
        rd(12'h00C, 32'h1, "R2 status after start");
        wr(12'h004, 32'h0);
        rd(12'h00C, 32'h1, "R2 zero bits leave channels alone");

        // R5 duty 3 of period 10
        idle(5);
        count_high(0, 50, hi);
        check("R5 high cycles duty3 period10", 32'(hi), 32'd15);

        // R9 direct writes dropped while running
        wr(ch_addr(0, 4), 32'h5);
        wr(ch_addr(0, 8), 32'h14);
        rd(ch_addr(0, 4), 32'h3, "R9 duty write ignored while running");
        rd(ch_addr(0, 8), 32'hA, "R9 period write ignored while running");

        // R10 staged duty, written right after a wrap
        wait_rise(0);
        wr(ch_addr(0, 16), 32'h7);
        rd(ch_addr(0, 4), 32'h3, "R10 duty unchanged before wrap");
        idle(12);
        rd(ch_addr(0, 4), 32'h7, "R10 duty applied at wrap");
        idle(2);
        count_high(0, 50, hi);
        check("R5 R10 high cycles duty7 period10", 32'(hi), 32'd35);

        // R10 staged period via mode bit 10
        wr(ch_addr(0, 0), 32'h400);
        rd(ch_addr(0, 0), 32'h400, "R10 mode target bit readback");
        wait_rise(0);
        wr(ch_addr(0, 16), 32'h10);
        rd(ch_addr(0, 8), 32'hA, "R10 period unchanged before wrap");
        idle(20);
        rd(ch_addr(0, 8), 32'h10, "R10 period applied at wrap");
        count_high(0, 64, hi);
        check("R5 R10 high cycles duty7 period16", 32'(hi), 32'd28);

        // R3 stop channel 0
        wr(12'h008, 32'h1);
        rd(12'h00C, 32'h0, "R3 status after stop");
        check("R3 idle level after stop", 32'(pwm_out[0]), 32'h0);
        wr(ch_addr(0, 4), 32'h2);
        rd(ch_addr(0, 4), 32'h2, "R9 duty accepted after stop");

        // R6 prescale 2 on channel 1
        wr(ch_addr(1, 0), 32'h2);
        wr(ch_addr(1, 4), 32'h2);
        wr(ch_addr(1, 8), 32'h5);
        rd(ch_addr(1, 0), 32'h2, "R6 prescale field readback");
        wr(12'h004, 32'h2);
        idle(10);
        count_high(1, 40, hi);
        check("R6 high cycles prescale2 duty2 period5", 32'(hi), 32'd16);

        // R7 inversion on channel 2
        wr(ch_addr(2, 0), 32'h200);
        idle(1);
        check("R7 R3 inverted idle level", 32'(pwm_out[2]), 32'h1);
        wr(ch_addr(2, 4), 32'h3);
        wr(ch_addr(2, 8), 32'h8);
        wr(12'h004, 32'h4);
        idle(3);
        count_high(2, 32, hi);
        check("R7 inverted high cycles duty3 period8", 32'(hi), 32'd20);

        // R8 zero period and full duty on channel 3
        wr(ch_addr(3, 4), 32'h5);
        wr(12'h004, 32'h8);
        idle(2);
        count_high(3, 20, hi);
        check("R8 zero period stays idle", 32'(hi), 32'd0);
        wr(12'h008, 32'h8);
        wr(ch_addr(3, 8), 32'h4);
        wr(ch_addr(3, 4), 32'h9);
        wr(12'h004, 32'h8);
        idle(2);
        count_high(3, 20, hi);
        check("R8 duty above period stays active", 32'(hi), 32'd20);

        // R2 R3 mixed status
        rd(12'h00C, 32'hE, "R2 status with three running");
        wr(12'h008, 32'h6);
        rd(12'h00C, 32'h8, "R3 partial stop");
        idle(1);
        check("R3 stopped channel1 idle", 32'(pwm_out[1]), 32'h0);
        check("R3 stopped inverted channel2 idle", 32'(pwm_out[2]), 32'h1);

        idle(3);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule